// File: doc/BRIEF.md
# Ratioed Clock-Domain Word Bridge

This block carries data words in both directions between a fast clock domain and a slow clock domain. The two clocks come from a common reference and their frequencies stand in a known rational ratio of at least 2. There is no FIFO, no handshake and no synchronizer on the data path. Safety comes from timing that is known in advance. A single-cycle enable, produced in the fast domain once per slow-clock period, marks the fast cycle in which a crossing may happen. The enable is placed in a window where the other clock's edge cannot disturb the flop that launches or captures the word. Because of this the latency through the bridge is fixed and short.

In the fast-to-slow direction, the fast side offers a word together with a launch enable. A launch register takes the word at that fast edge and then holds it. The slow domain samples the launch register on every slow edge. In the slow-to-fast direction, the slow side registers a word on its own rising edge. The fast domain captures it at the fast edge that ends a cycle in which the capture enable is high.

Each word travels with a marker bit that inverts whenever a new word is launched. The receiving side compares the marker with the last one it consumed. This lets it tell a fresh word from held data, so every word comes out exactly once, as a single-cycle valid pulse in the receiving domain. One asynchronous active-low reset input clears the block. It is released separately into each domain through a short synchronizer.

Top module: `xfer_ratio_bridge`

## Requirements
- R1: A fast-to-slow word is accepted at a rising `fast_clk` edge where both `fs_launch_en` and `fs_in_valid` are 1. It later appears once on `fs_out_data`, with `fs_out_valid` high for exactly one `slow_clk` cycle.
- R2: A word offered with `fs_in_valid` = 1 while `fs_launch_en` = 0 is ignored. No slow-side valid pulse follows, and `fs_out_data` keeps its previous value.
- R3: A slow-to-fast word is taken at a rising `slow_clk` edge where `sf_in_valid` = 1. A slow cycle with `sf_in_valid` = 0 launches nothing.
- R4: A launched slow-to-fast word is captured at the first `fast_clk` edge that ends a cycle with `sf_capture_en` = 1. One fast cycle later it is presented on `sf_out_data` with a one-cycle `sf_out_valid` pulse.
- R5: A capture enable (or a slow-side sample) that finds no new word since the last one delivers nothing. Held data is never delivered twice.
- R6: Every word is delivered exactly once and in the order it was offered, in both directions. This holds for clock ratios 2, 2.5, 2.75, 3 and 3.5, provided one enable pulse is placed in the first full fast cycle after each slow rising edge.
- R7: `fs_out_data` and `sf_out_data` change only in cycles where their valid outputs are high. When the capture enable is given at most once per slow period, `sf_out_valid` is never high on two fast cycles in a row.
- R8: While reset is applied, and after it is released until the first word arrives, both valid outputs are 0 and both data outputs are 0.
- R9: Pulling `arst_n` low clears both valid and data outputs at once, without waiting for a clock edge. Release takes effect in each domain only after `SYNC_STAGES` edges of that domain's clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk | input | 1 | Fast domain clock |
| slow_clk | input | 1 | Slow domain clock, rational fraction of fast_clk |
| arst_n | input | 1 | Asynchronous active-low reset |
| fs_launch_en | input | 1 | Fast-domain enable marking the launch cycle for fast-to-slow words |
| fs_in_valid | input | 1 | Fast-side word offered this fast cycle |
| fs_in_data | input | DATA_W | Fast-side word |
| fs_out_valid | output | 1 | Slow-domain pulse: new fast-to-slow word on fs_out_data |
| fs_out_data | output | DATA_W | Delivered fast-to-slow word, held between pulses |
| sf_in_valid | input | 1 | Slow-side word offered this slow cycle |
| sf_in_data | input | DATA_W | Slow-side word |
| sf_capture_en | input | 1 | Fast-domain enable marking the capture cycle for slow-to-fast words |
| sf_out_valid | output | 1 | Fast-domain pulse: new slow-to-fast word on sf_out_data |
| sf_out_data | output | DATA_W | Delivered slow-to-fast word, held between pulses |

## Verification
The bench runs the bridge at five clock ratios, including the fractional ratios 2.5 and 2.75. At these ratios the distance between enables in fast cycles varies from one slow period to the next. A bridge that sampled on level rather than on a marker change would repeat a word or drop one, and the ordered scoreboard reports that as a mismatch or as words left over. Idle slots inside bursts, and back-to-back words on the slow side, target a receiver that re-delivers held data: its delivery count would exceed the number sent. A word offered outside the launch enable checks that the launch register is really gated; an ungated register would produce an extra slow-side pulse or overwrite the held output. A reset asserted between clock edges checks that the outputs clear at once.

// File: rtl/xfer_pkg.sv
`timescale 1ns/1ps
package xfer_pkg;

  // Smallest synchronizer depth allowed for the reset release chain.
  localparam int unsigned XFER_MIN_SYNC = 2;

  // Clamp a requested synchronizer depth to the legal minimum.
  function automatic int unsigned xfer_sync_depth(input int unsigned req);
    return (req < XFER_MIN_SYNC) ? XFER_MIN_SYNC : req;
  endfunction

endpackage

// File: rtl/xfer_rst_sync.sv
`timescale 1ns/1ps
module xfer_rst_sync
  import xfer_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  localparam int unsigned DEPTH = xfer_sync_depth(STAGES);

  logic [DEPTH-1:0] chain_q;
  logic [DEPTH-1:0] chain_d;

  // Shift ones in from the bottom; assertion is asynchronous, release takes DEPTH edges.
  always_comb begin
    chain_d = {chain_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_o = chain_q[DEPTH-1];

endmodule

// File: rtl/xfer_launch.sv
`timescale 1ns/1ps
module xfer_launch #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              word_valid,
  input  logic [DATA_W-1:0] word_data,
  output logic [DATA_W-1:0] q_data,
  output logic              q_tog
);

  logic              take;
  logic [DATA_W-1:0] data_d;
  logic              tog_d;
  logic [DATA_W-1:0] data_q;
  logic              tog_q;

  assign take = load_en & word_valid;

  // Next-state: new word and inverted marker, used only when take is set.
  always_comb begin
    data_d = word_data;
    tog_d  = ~tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      tog_q  <= 1'b0;
    end else if (take) begin
      data_q <= data_d;
      tog_q  <= tog_d;
    end
  end

  assign q_data = data_q;
  assign q_tog  = tog_q;

  // R2: without a gated offer the launch register holds, so the far side sees stable data.
  a_r2_launch_hold : assert property (@(posedge clk) disable iff (!rst_n)
    !(load_en && word_valid) |=> ($stable(q_data) && $stable(q_tog)));

  // R1: every accepted word flips the marker exactly once.
  a_r1_marker_flip : assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && word_valid) |=> (q_tog != $past(q_tog)));

endmodule

// File: rtl/xfer_capture.sv
`timescale 1ns/1ps
module xfer_capture #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_en,
  input  logic [DATA_W-1:0] lane_data,
  input  logic              lane_tog,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  logic [DATA_W-1:0] cap_data_q;
  logic              cap_tog_q;
  logic              seen_q;
  logic              fresh;
  logic              seen_d;
  logic              valid_d;
  logic [DATA_W-1:0] odata_d;
  logic              valid_q;
  logic [DATA_W-1:0] odata_q;

  // Capture stage: the only flop that looks across the domain boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_data_q <= '0;
      cap_tog_q  <= 1'b0;
    end else if (sample_en) begin
      cap_data_q <= lane_data;
      cap_tog_q  <= lane_tog;
    end
  end

  // A word is new when its marker differs from the last one consumed.
  assign fresh = cap_tog_q ^ seen_q;

  always_comb begin
    seen_d  = cap_tog_q;
    valid_d = fresh;
    odata_d = fresh ? cap_data_q : odata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      valid_q <= 1'b0;
      odata_q <= '0;
    end else begin
      seen_q  <= seen_d;
      valid_q <= valid_d;
      odata_q <= odata_d;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = odata_q;

  // R5: capture stage holds when not enabled, so held data cannot look new.
  a_r5_capture_hold : assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> ($stable(cap_tog_q) && $stable(cap_data_q)));

  // R7: delivered data moves only together with the valid pulse.
  a_r7_data_with_valid : assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_data) |-> out_valid);

  // R5: after a delivery the marker is consumed, so the same word cannot pulse again.
  a_r5_no_repeat : assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !sample_en) |=> !out_valid);

endmodule

// File: rtl/xfer_ratio_bridge.sv
`timescale 1ns/1ps
module xfer_ratio_bridge #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              fast_clk,
  input  logic              slow_clk,
  input  logic              arst_n,
  input  logic              fs_launch_en,
  input  logic              fs_in_valid,
  input  logic [DATA_W-1:0] fs_in_data,
  output logic              fs_out_valid,
  output logic [DATA_W-1:0] fs_out_data,
  input  logic              sf_in_valid,
  input  logic [DATA_W-1:0] sf_in_data,
  input  logic              sf_capture_en,
  output logic              sf_out_valid,
  output logic [DATA_W-1:0] sf_out_data
);

  logic              fast_rst_n;
  logic              slow_rst_n;
  logic [DATA_W-1:0] fs_lane_data;
  logic              fs_lane_tog;
  logic [DATA_W-1:0] sf_lane_data;
  logic              sf_lane_tog;

  xfer_rst_sync #(.STAGES(SYNC_STAGES)) u_fast_rst (
    .clk     (fast_clk),
    .arst_n  (arst_n),
    .rst_n_o (fast_rst_n)
  );

  xfer_rst_sync #(.STAGES(SYNC_STAGES)) u_slow_rst (
    .clk     (slow_clk),
    .arst_n  (arst_n),
    .rst_n_o (slow_rst_n)
  );

  // Fast to slow: gated launch on the fast clock, free-running capture on the slow clock.
  xfer_launch #(.DATA_W(DATA_W)) u_fs_launch (
    .clk        (fast_clk),
    .rst_n      (fast_rst_n),
    .load_en    (fs_launch_en),
    .word_valid (fs_in_valid),
    .word_data  (fs_in_data),
    .q_data     (fs_lane_data),
    .q_tog      (fs_lane_tog)
  );

  xfer_capture #(.DATA_W(DATA_W)) u_fs_capture (
    .clk       (slow_clk),
    .rst_n     (slow_rst_n),
    .sample_en (1'b1),
    .lane_data (fs_lane_data),
    .lane_tog  (fs_lane_tog),
    .out_valid (fs_out_valid),
    .out_data  (fs_out_data)
  );

  // Slow to fast: launch on every slow edge, capture gated on the fast clock.
  xfer_launch #(.DATA_W(DATA_W)) u_sf_launch (
    .clk        (slow_clk),
    .rst_n      (slow_rst_n),
    .load_en    (1'b1),
    .word_valid (sf_in_valid),
    .word_data  (sf_in_data),
    .q_data     (sf_lane_data),
    .q_tog      (sf_lane_tog)
  );

  xfer_capture #(.DATA_W(DATA_W)) u_sf_capture (
    .clk       (fast_clk),
    .rst_n     (fast_rst_n),
    .sample_en (sf_capture_en),
    .lane_data (sf_lane_data),
    .lane_tog  (sf_lane_tog),
    .out_valid (sf_out_valid),
    .out_data  (sf_out_data)
  );

  // R7: one capture enable per slow period means no back-to-back fast-side pulses.
  a_r7_single_pulse : assert property (@(posedge fast_clk) disable iff (!fast_rst_n)
    (sf_out_valid && !sf_capture_en) |=> !sf_out_valid);

  // R9: the released reset never leaves an output pulse standing in the first cycle.
  a_r9_clear_after_release : assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
    $rose(slow_rst_n) |-> !fs_out_valid);

endmodule

// File: tb/tb_xfer_ratio_bridge.sv
`timescale 1ns/1ps
module tb_xfer_ratio_bridge;

  localparam realtime CLK_PERIOD_FAST = 4.0;
  localparam int      DW              = 16;

  logic          fast_clk;
  logic          slow_clk;
  logic          arst_n;
  logic          fs_launch_en;
  logic          fs_in_valid;
  logic [DW-1:0] fs_in_data;
  logic          fs_out_valid;
  logic [DW-1:0] fs_out_data;
  logic          sf_in_valid;
  logic [DW-1:0] sf_in_data;
  logic          sf_capture_en;
  logic          sf_out_valid;
  logic [DW-1:0] sf_out_data;

  int      checks   = 0;
  int      failures = 0;
  bit      done     = 1'b0;
  realtime slow_period = 10.0;
  bit      slow_tick = 1'b0;
  bit      bad_req   = 1'b0;
  int      fs_pend[$];
  int      sf_pend[$];
  int      fs_exp[$];
  int      sf_exp[$];
  int      fs_rx = 0;
  int      sf_rx = 0;
  int      r7_viol = 0;
  logic [DW-1:0] fs_prev = '0;
  logic [DW-1:0] sf_prev = '0;

  xfer_ratio_bridge #(.DATA_W(DW), .SYNC_STAGES(2)) dut (
    .fast_clk      (fast_clk),
    .slow_clk      (slow_clk),
    .arst_n        (arst_n),
    .fs_launch_en  (fs_launch_en),
    .fs_in_valid   (fs_in_valid),
    .fs_in_data    (fs_in_data),
    .fs_out_valid  (fs_out_valid),
    .fs_out_data   (fs_out_data),
    .sf_in_valid   (sf_in_valid),
    .sf_in_data    (sf_in_data),
    .sf_capture_en (sf_capture_en),
    .sf_out_valid  (sf_out_valid),
    .sf_out_data   (sf_out_data)
  );

  // Fast clock: edges on whole nanoseconds.
  initial begin
    fast_clk = 1'b0;
    forever #(CLK_PERIOD_FAST / 2.0) fast_clk = ~fast_clk;
  end

  // Slow clock: rising edges on half-nanosecond offsets, period read once per cycle.
  initial begin
    slow_clk = 1'b0;
    #0.5;
    forever begin
      realtime hp;
      hp = slow_period / 2.0;
      slow_clk = 1'b1;
      #hp;
      slow_clk = 1'b0;
      #hp;
    end
  end

  initial begin
    forever begin
      @(posedge slow_clk);
      slow_tick = 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
    end
  endtask

  // Fast-side driver: one enable in the first full fast cycle after each slow edge.
  initial begin
    fs_launch_en  = 1'b0;
    sf_capture_en = 1'b0;
    fs_in_valid   = 1'b0;
    fs_in_data    = '0;
    forever begin
      bit en;
      int w;
      @(negedge fast_clk);
      en = slow_tick;
      slow_tick = 1'b0;
      fs_launch_en  = en;
      sf_capture_en = en;
      fs_in_valid   = 1'b0;
      if (en && fs_pend.size() > 0) begin
        w = fs_pend.pop_front();
        if (w >= 0) begin
          fs_in_valid = 1'b1;
          fs_in_data  = w[DW-1:0];
          fs_exp.push_back(w);
        end
      end else if (!en && bad_req) begin
        bad_req     = 1'b0;
        fs_in_valid = 1'b1;
        fs_in_data  = 16'hDEAD;
      end
    end
  end

  // Slow-side driver: at most one word per slow cycle.
  initial begin
    sf_in_valid = 1'b0;
    sf_in_data  = '0;
    forever begin
      int w;
      @(negedge slow_clk);
      sf_in_valid = 1'b0;
      if (sf_pend.size() > 0) begin
        w = sf_pend.pop_front();
        if (w >= 0) begin
          sf_in_valid = 1'b1;
          sf_in_data  = w[DW-1:0];
          sf_exp.push_back(w);
        end
      end
    end
  end

  // Slow-domain monitor for fast-to-slow words.
  initial begin
    forever begin
      int e;
      @(negedge slow_clk);
      if (arst_n && fs_out_valid) begin
        fs_rx++;
        if (fs_exp.size() == 0) begin
          check(1'b0, "R5", "unexpected f2s word", {16'h0, fs_out_data}, 32'h0);
        end else begin
          e = fs_exp.pop_front();
          check(fs_out_data == e[DW-1:0], "R6", "f2s order", {16'h0, fs_out_data}, e);
        end
      end else if (arst_n && fs_out_data != fs_prev) begin
        r7_viol++;
      end
      fs_prev = fs_out_data;
    end
  end

  // Fast-domain monitor for slow-to-fast words.
  initial begin
    forever begin
      int e;
      @(negedge fast_clk);
      if (arst_n && sf_out_valid) begin
        sf_rx++;
        if (sf_exp.size() == 0) begin
          check(1'b0, "R5", "unexpected s2f word", {16'h0, sf_out_data}, 32'h0);
        end else begin
          e = sf_exp.pop_front();
          check(sf_out_data == e[DW-1:0], "R6", "s2f order", {16'h0, sf_out_data}, e);
        end
      end else if (arst_n && sf_out_data != sf_prev) begin
        r7_viol++;
      end
      sf_prev = sf_out_data;
    end
  end

  task automatic run_phase(input realtime p, input int n, input int base);
    arst_n = 1'b0;
    #(2.0 * p);
    slow_period = p;
    fs_pend.delete();
    sf_pend.delete();
    fs_exp.delete();
    sf_exp.delete();
    #(3.0 * p);
    check(fs_out_valid == 1'b0 && sf_out_valid == 1'b0, "R8", "valid in reset",
          {30'h0, fs_out_valid, sf_out_valid}, 32'h0);
    arst_n = 1'b1;
    #(6.0 * p);
    fs_rx = 0;
    sf_rx = 0;
    check(fs_out_valid == 1'b0 && fs_out_data == '0, "R8", "f2s after release",
          {15'h0, fs_out_valid, fs_out_data}, 32'h0);
    check(sf_out_valid == 1'b0 && sf_out_data == '0, "R8", "s2f after release",
          {15'h0, sf_out_valid, sf_out_data}, 32'h0);
    for (int i = 0; i < n; i++) begin
      fs_pend.push_back(base + i);
      if (i % 4 == 3) fs_pend.push_back(-1);
      sf_pend.push_back(base + 'h800 + i);
      if (i % 5 == 1) sf_pend.push_back(-1);
      if (i % 7 == 4) sf_pend.push_back(-1);
    end
    while (fs_pend.size() != 0 || sf_pend.size() != 0) @(posedge slow_clk);
    #(10.0 * p);
    check(fs_exp.size() == 0, "R6", "f2s words left", fs_exp.size(), 0);
    check(sf_exp.size() == 0, "R6", "s2f words left", sf_exp.size(), 0);
    check(fs_rx == n, "R1", "f2s delivered count", fs_rx, n);
    check(sf_rx == n, "R4", "s2f delivered count", sf_rx, n);
    check(sf_rx == n, "R3 R5", "s2f idle slots add nothing", sf_rx, n);
    // R2: offer outside the launch enable, then confirm nothing moved.
    bad_req = 1'b1;
    #(6.0 * p);
    check(fs_rx == n, "R2", "ignored offer delivered", fs_rx, n);
    check(fs_out_data == DW'(base + n - 1), "R2", "held f2s data",
          {16'h0, fs_out_data}, base + n - 1);
    check(r7_viol == 0, "R7", "data moved without valid", r7_viol, 0);
  endtask

  initial begin
    arst_n = 1'b0;
    #(1.0);
    check(fs_out_valid == 1'b0 && sf_out_valid == 1'b0, "R8", "valid at start",
          {30'h0, fs_out_valid, sf_out_valid}, 32'h0);
    run_phase(8.0,  30, 'h1000);
    run_phase(10.0, 30, 'h2000);
    run_phase(11.0, 30, 'h3000);
    run_phase(12.0, 30, 'h4000);
    run_phase(14.0, 30, 'h5000);
    // R9: asynchronous clear between clock edges.
    check(fs_out_data != '0 && sf_out_data != '0, "R9", "outputs loaded before reset",
          {fs_out_data, sf_out_data}, 32'h0);
    @(posedge fast_clk);
    #1.3;
    arst_n = 1'b0;
    #0.2;
    check(fs_out_data == '0 && sf_out_data == '0, "R9", "async clear of data",
          {fs_out_data, sf_out_data}, 32'h0);
    check(fs_out_valid == 1'b0 && sf_out_valid == 1'b0, "R9", "async clear of valid",
          {30'h0, fs_out_valid, sf_out_valid}, 32'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD_FAST * 100000.0);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete got=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule